// File: doc/BRIEF.md
# Byte-or-Word Parallel DAC Loader

This block is the parallel-bus front end of a four-channel, 14-bit digital-to-analog converter. A host drives a code onto a 14-bit data bus, picks a channel with two address lines and completes the write with the rising edge of an active-low write strobe. Each channel has an input register that this write fills. Behind the input registers sits a bank of DAC latches whose contents are the codes that the converters actually see.

The host may write a full 14-bit word in one cycle. On an 8-bit bus it may instead write in two steps. First it writes the lower eight bits with the byte-shift control high and the upper six bus lines tied to zero. It then writes the six top bits on the lowest bus lines with the byte-shift control low. A broadcast bit sends one write to all four input registers at once. Pulling the active-low load strobe low copies all four input registers into the latches together. Pulling the active-low clear input low switches every output to the ground-sense level. The outputs stay there until the next load.

All inputs are sampled on the rising edge of `clk`. The write strobe is edge-detected in this clock domain.

Top module: `dac_parallel_loader`

## Requirements
- R1: After reset every DAC latch reads zero, every input register holds zero and `out_grounded` is 0.
- R2: When `wr_n` is sampled high one clock after it was sampled low, a write occurs. With `byte_sel` = 1 the write stores all 14 bits of `bus_data` into the input register selected by `chan_addr`, where 0 to 3 select channels 1 to 4 in binary order. Holding `wr_n` at either level causes no further write.
- R3: A write with `byte_sel` = 0 stores `bus_data[5:0]` into bits 13:8 of the selected input register, so `bus_data[5]` becomes the MSB.
- R4: A write with `byte_sel` = 0 leaves bits 7:0 of the selected input register unchanged. Bus bits 13:6 have no effect on that write.
- R5: A write with `bcast` = 1 applies the same merge to all four input registers, whatever `chan_addr` holds.
- R6: A write with `bcast` = 0 leaves the other three input registers unchanged.
- R7: A clock edge with `load_n` low copies all four input registers into their latches in the same cycle, and `dac_code` then shows the new codes. While `load_n` is high the latches hold, even across writes.
- R8: A clock edge with `clr_n` low sets `out_grounded` to 1. It stays 1 after `clr_n` returns high, until a load. Clear wins over a load in the same cycle, although that load still updates the latches.
- R9: A clock edge with `load_n` low and `clr_n` high returns `out_grounded` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 14 | Parallel data bus |
| chan_addr | input | 2 | Channel select, 0 to 3 for channels 1 to 4 |
| bcast | input | 1 | Sends the write to all channels |
| wr_n | input | 1 | Active-low write strobe; its rising edge commits the write |
| byte_sel | input | 1 | 1: full-word or low-byte write, 0: top six bits from bus bits 5:0 |
| load_n | input | 1 | Active-low simultaneous latch transfer |
| clr_n | input | 1 | Active-low clear to ground-sense level |
| dac_code | output | 56 | Latched codes, channel 1 in bits 13:0, channel 4 in bits 55:42 |
| out_grounded | output | 1 | 1 while the outputs sit at the ground-sense level |

## Verification
Word writes sweep every channel with spread-out codes, including all zeros and all ones. Each is followed by a load that checks all four channels, which shows whether the address decode reaches only its own register. Split writes sweep low bytes and six-bit top values on every channel with garbage on bus bits 13:6. Their results tell a correct merge apart from one that loses the low byte or takes the top bits from the wrong lines. Broadcast, loads that are withheld, a strobe held low while the data changes, and clear sequences that overlap and follow a load separate the latch and clamp orderings from one another.

// File: rtl/dac_ldr_pkg.sv
package dac_ldr_pkg;
  localparam int unsigned CODE_W = 14;
  localparam int unsigned LO_W   = 8;
  localparam int unsigned HI_W   = CODE_W - LO_W;

  typedef logic [CODE_W-1:0] code_t;

  // Full load takes the whole bus; split load puts bus[HI_W-1:0] on top.
  function automatic code_t merge_code(input code_t old_val, input code_t bus_val,
                                       input logic full_load);
    code_t res;
    if (full_load) res = bus_val;
    else           res = {bus_val[HI_W-1:0], old_val[LO_W-1:0]};
    return res;
  endfunction
endpackage

// File: rtl/dac_chan_decode.sv
module dac_chan_decode #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bcast,
  output logic [NUM_CH-1:0] we
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign we[g] = wr_evt && (bcast || (addr == ADDR_W'(g)));
  end

  AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bcast) |-> (we == {NUM_CH{1'b1}})); // R5
  AST_SINGLE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !bcast) |-> ($onehot(we) && we[addr])); // R6
  AST_NO_EVT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |-> (we == '0)); // R2
endmodule

// File: rtl/dac_input_bank.sv
module dac_input_bank
  import dac_ldr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             we,
  input  logic [CODE_W-1:0]             bus_val,
  input  logic                          full_load,
  output logic [NUM_CH-1:0][CODE_W-1:0] in_regs
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     in_regs[g] <= '0;
      else if (we[g]) in_regs[g] <= merge_code(in_regs[g], bus_val, full_load);
    end

    AST_HI_FROM_LOW_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      (we[g] && !full_load) |=> (in_regs[g][CODE_W-1:LO_W] == $past(bus_val[HI_W-1:0]))); // R3
    AST_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (we[g] && !full_load) |=> (in_regs[g][LO_W-1:0] == $past(in_regs[g][LO_W-1:0]))); // R4
    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we[g] && full_load) |=> (in_regs[g] == $past(bus_val))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we[g] |=> $stable(in_regs[g])); // R6
  end
endmodule

// File: rtl/dac_latch_stage.sv
module dac_latch_stage
  import dac_ldr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0][CODE_W-1:0] in_regs,
  input  logic                          load_n,
  input  logic                          clr_n,
  output logic [NUM_CH-1:0][CODE_W-1:0] latches,
  output logic                          grounded
);
  logic load_evt;
  logic clear_evt;
  assign load_evt  = !load_n;
  assign clear_evt = !clr_n;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latches[g] <= '0;
      else if (load_evt) latches[g] <= in_regs[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         grounded <= 1'b0;
    else if (clear_evt) grounded <= 1'b1;
    else if (load_evt)  grounded <= 1'b0;
  end

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (latches == $past(in_regs))); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(latches)); // R7
  AST_CLEAR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> grounded); // R8
  AST_CLEAR_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (grounded && !load_evt) |=> grounded); // R8
  AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !clear_evt) |=> !grounded); // R9
endmodule

// File: rtl/dac_parallel_loader.sv
module dac_parallel_loader
  import dac_ldr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CODE_W-1:0]        bus_data,
  input  logic [ADDR_W-1:0]        chan_addr,
  input  logic                     bcast,
  input  logic                     wr_n,
  input  logic                     byte_sel,
  input  logic                     load_n,
  input  logic                     clr_n,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic                     out_grounded
);
  logic                          wr_q;
  logic                          wr_evt;
  logic [NUM_CH-1:0]             we;
  logic [NUM_CH-1:0][CODE_W-1:0] in_regs;
  logic [NUM_CH-1:0][CODE_W-1:0] latches;

  // Strobe history; resets high so leaving reset is not a write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end
  assign wr_evt = wr_n && !wr_q;

  AST_WR_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> (wr_n && $past(!wr_n))); // R2

  dac_chan_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_evt (wr_evt),
    .addr   (chan_addr),
    .bcast  (bcast),
    .we     (we)
  );

  dac_input_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (we),
    .bus_val   (bus_data),
    .full_load (byte_sel),
    .in_regs   (in_regs)
  );

  dac_latch_stage #(.NUM_CH(NUM_CH)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_regs  (in_regs),
    .load_n   (load_n),
    .clr_n    (clr_n),
    .latches  (latches),
    .grounded (out_grounded)
  );

  assign dac_code = latches;

  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (dac_code == '0 && !out_grounded)); // R1
endmodule

// File: tb/dac_parallel_loader_tb.sv
module dac_parallel_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int WATCHDOG = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [13:0]       bus_data = '0;
  logic [1:0]        chan_addr = '0;
  logic              bcast = 1'b0;
  logic              wr_n = 1'b1;
  logic              byte_sel = 1'b1;
  logic              load_n = 1'b1;
  logic              clr_n = 1'b1;
  logic [NCH*14-1:0] dac_code;
  logic              out_grounded;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int exp_in  [NCH];
  int exp_lat [NCH];
  bit exp_gnd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_parallel_loader u_dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .chan_addr(chan_addr),
    .bcast(bcast), .wr_n(wr_n), .byte_sel(byte_sel), .load_n(load_n),
    .clr_n(clr_n), .dac_code(dac_code), .out_grounded(out_grounded)
  );

  task automatic check_outs(input string req);
    for (int c = 0; c < NCH; c++) begin
      int act;
      act = int'(dac_code[c*14 +: 14]);
      checks++;
      if (act != exp_lat[c]) begin
        fails++;
        $display("FAIL %s: channel %0d code actual %0h expected %0h", req, c+1, act, exp_lat[c]);
      end
    end
    checks++;
    if (out_grounded !== exp_gnd) begin
      fails++;
      $display("FAIL %s: out_grounded actual %0b expected %0b", req, out_grounded, exp_gnd);
    end
  endtask

  // Model: full load copies the bus; split load puts the low six bus bits above the kept byte.
  function automatic int model_merge(input int old, input int bus, input bit full);
    if (full) return bus % 16384;
    return (bus % 64) * 256 + (old % 256);
  endfunction

  task automatic do_write(input int addr, input int data, input bit full, input bit bc);
    @(negedge clk);
    bus_data = 14'(data); chan_addr = 2'(addr); byte_sel = full; bcast = bc; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++)
      if (bc || c == addr) exp_in[c] = model_merge(exp_in[c], data, full);
  endtask

  task automatic do_load();
    @(negedge clk);
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    for (int c = 0; c < NCH; c++) exp_lat[c] = exp_in[c];
    if (clr_n) exp_gnd = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin exp_in[c] = 0; exp_lat[c] = 0; end
    exp_gnd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 reset");

    // R2 / R6 / R7: word writes on every channel, each then loaded.
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 18; k++) begin
        int v;
        v = (k == 16) ? 0 : (k == 17) ? 16383 : (k * 2651 + c * 4951 + 7) % 16384;
        do_write(c, v, 1'b1, 1'b0);
        check_outs("R7 hold before load");
        do_load();
        check_outs("R2 R6 word write");
      end
    end

    // R2: strobe held low while data changes; only the value at the rising edge counts.
    @(negedge clk);
    bus_data = 14'h0123; chan_addr = 2'd1; byte_sel = 1'b1; bcast = 1'b0; wr_n = 1'b0;
    repeat (3) begin @(negedge clk); bus_data = bus_data + 14'h0111; end
    wr_n = 1'b1;
    @(negedge clk);
    exp_in[1] = (16'h0123 + 3 * 16'h0111) % 16384;
    repeat (3) @(negedge clk);
    do_load();
    check_outs("R2 edge only");

    // R3 / R4: split writes, garbage on bus bits 13:6 during the top write.
    for (int c = 0; c < NCH; c++) begin
      for (int lo = 0; lo < 256; lo += 17) begin
        int hi;
        hi = (lo * 3 + c * 11) % 64;
        do_write(c, lo, 1'b1, 1'b0);
        do_write(c, (((lo + c) % 256) * 64) + hi, 1'b0, 1'b0);
        do_load();
        check_outs("R3 R4 split write");
      end
    end

    // R5: broadcast with both merges.
    do_write(2, 14'h2A5C, 1'b1, 1'b1);
    do_load();
    check_outs("R5 broadcast word");
    do_write(0, 14'h3FC0 | 14'h15, 1'b0, 1'b1);
    do_load();
    check_outs("R5 broadcast top bits");

    // R8: clear sets and persists.
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1; exp_gnd = 1'b1;
    check_outs("R8 clear sets");
    do_write(3, 14'h1111, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check_outs("R8 clear persists");
    // Clear and load together: latches update, clamp stays.
    @(negedge clk); clr_n = 1'b0; load_n = 1'b0;
    @(negedge clk); clr_n = 1'b1; load_n = 1'b1;
    for (int c = 0; c < NCH; c++) exp_lat[c] = exp_in[c];
    exp_gnd = 1'b1;
    check_outs("R8 clear over load");

    // R9: load alone releases.
    do_write(0, 14'h0abc, 1'b1, 1'b0);
    do_load();
    check_outs("R9 load releases");

    // R1: reset mid-run.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) begin exp_in[c] = 0; exp_lat[c] = 0; end
    exp_gnd = 1'b0;
    @(negedge clk);
    check_outs("R1 reset again");
    do_load();
    check_outs("R1 input registers cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule